// File: doc/BRIEF.md
# Floating-Point Control Register and Branch Unit

This block is the control half of a floating-point coprocessor that sits next to an integer pipeline. It keeps two control words: a read-only identification word and a writable control/status word. It moves control words to and from the integer side. It turns the two-bit rounding field into a one-hot select for the arithmetic units. It resolves the four coprocessor branch forms from the compare-condition bit. It also raises a divide-by-zero indication when the data path reports a zero divisor and the matching enable bit is set.

The pipeline presents one operation per cycle: `op_valid` with an operation code, a register index, write data, the instruction PC, the branch immediate and a zero-divisor flag. Every result comes out of a register one clock later. If the coprocessor-usable input is low, the operation only raises a fault and holds the PC.

Top module: `fpu_ctrl_branch`

## Requirements
- R1: After synchronous reset the control/status word is 0, `rnd_sel` is 4'b0001 (round to nearest even), and every pulse output (`done`, `fault_unusable`, `br_taken`, `nullify_slot`, `int_wen`, `div0_flag`) is 0.
- R2: A read (op 0) of index 31 returns the control/status word, and a read of index 0 returns the parameter `IMPL_REV`. Each is sign-extended from 32 to 64 bits on `int_rdata`, with `int_wen` high, one cycle after issue.
- R3: A read of any index other than 0 or 31 leaves `int_wen` low.
- R4: A write (op 1) to index 31 stores all 32 bits of `int_wdata`, exception-enable field [11:7] included. A write to any other index leaves the word unchanged.
- R5: `rnd_sel` is one-hot on control bits [1:0]. Bit 0 means nearest-even (mode 0), bit 1 toward zero (mode 1), bit 2 toward +infinity (mode 2) and bit 3 toward -infinity (mode 3). It changes on the same clock edge that writes the word.
- R6: The branch condition is bit 23 of the control/status word. Branch-on-false (ops 2 and 4) is taken when the bit is 0, and branch-on-true (ops 3 and 5) is taken when it is 1.
- R7: A taken branch sets `next_pc` to pc + 4 + (sign-extended 16-bit immediate × 4). A branch that is not taken, and every other accepted operation, sets `next_pc` to pc + 4.
- R8: The likely forms (ops 4 and 5) raise `nullify_slot` when not taken. The plain forms never raise it.
- R9: With `cop_usable` low, an operation raises `fault_unusable` and sets `next_pc` to pc. It writes nothing, and leaves `int_wen`, `br_taken`, `nullify_slot` and `div0_flag` low.
- R10: A divide (op 6) with `divisor_zero` high raises `div0_flag` only when bit 10 of the control/status word is set.
- R11: `done` follows `op_valid` one cycle later. Op 7 (other arithmetic) only advances the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | 0 read, 1 write, 2 br-false, 3 br-true, 4 br-false-likely, 5 br-true-likely, 6 divide, 7 other |
| cop_usable | input | 1 | Coprocessor enabled |
| ctl_idx | input | 5 | Control register index |
| int_wdata | input | 32 | Word from the integer side |
| pc | input | 32 | PC of the operation |
| imm | input | 16 | Branch offset in words |
| divisor_zero | input | 1 | Divide operand is zero |
| done | output | 1 | Operation completed |
| fault_unusable | output | 1 | Coprocessor-unusable fault |
| next_pc | output | 32 | Following PC |
| br_taken | output | 1 | Branch taken |
| nullify_slot | output | 1 | Cancel the delay slot |
| int_wen | output | 1 | Write `int_rdata` to the integer register |
| int_rdata | output | 64 | Sign-extended control word |
| rnd_sel | output | 4 | One-hot rounding select |
| div0_flag | output | 1 | Divide-by-zero indication |

## Verification
A corrupted control/status word shows up in three ways. It shows in `rnd_sel` on the very next edge. It shows in the direction of the next branch one cycle after issue. It shows in the value returned by a read of index 31. Since the bench compares every output on every clock against a behavioural model, a stray write, a lost write or a wrongly decoded rounding mode is reported within one cycle of the first operation that depends on it. A fault path that leaks a side effect is caught the same way, on the cycle after the unusable operation.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
  typedef enum logic [2:0] {
    FOP_RD    = 3'd0,
    FOP_WR    = 3'd1,
    FOP_BF    = 3'd2,
    FOP_BT    = 3'd3,
    FOP_BFL   = 3'd4,
    FOP_BTL   = 3'd5,
    FOP_DIV   = 3'd6,
    FOP_ARITH = 3'd7
  } fop_e;

  localparam int CTL_W     = 32;
  localparam int IDX_W     = 5;
  localparam int CSR_IDX   = 31;
  localparam int ID_IDX    = 0;
  localparam int COND_BIT  = 23;
  localparam int DZ_EN_BIT = 10;
  localparam int RM_W      = 2;
  localparam int RM_MODES  = 1 << RM_W;
endpackage

// File: rtl/fcb_ctrl_regs.sv
module fcb_ctrl_regs
  import fcb_pkg::*;
#(
  parameter logic [CTL_W-1:0] IMPL_REV = 32'h0000_0A00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [CTL_W-1:0] wr_data,
  output logic [CTL_W-1:0] csr_q,
  output logic [CTL_W-1:0] csr_d,
  output logic [CTL_W-1:0] rd_data,
  output logic             rd_hit
);
  localparam logic [IDX_W-1:0] CSR_SEL = IDX_W'(CSR_IDX);
  localparam logic [IDX_W-1:0] ID_SEL  = IDX_W'(ID_IDX);

  always_comb begin
    csr_d = csr_q;
    if (wr_en && idx == CSR_SEL) csr_d = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) csr_q <= '0;
    else     csr_q <= csr_d;
  end

  always_comb begin
    rd_hit  = 1'b1;
    rd_data = '0;
    if (idx == CSR_SEL)     rd_data = csr_q;
    else if (idx == ID_SEL) rd_data = IMPL_REV;
    else                    rd_hit  = 1'b0;
  end

  // R4: the word only moves on a write that targets index 31
  p_csr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && idx == CSR_SEL) |=> csr_q == $past(csr_q));
  p_csr_load_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == CSR_SEL) |=> csr_q == $past(wr_data));
endmodule

// File: rtl/fcb_round_decode.sv
module fcb_round_decode
  import fcb_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [RM_W-1:0]     mode_next,
  output logic [RM_MODES-1:0] sel_q
);
  logic [RM_MODES-1:0] sel_d;

  for (genvar k = 0; k < RM_MODES; k++) begin : g_mode
    assign sel_d[k] = (mode_next == RM_W'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= RM_MODES'(1);
    else     sel_q <= sel_d;
  end

  // R5: exactly one rounding behaviour is selected at all times
  p_rnd_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(sel_q) == 1);
endmodule

// File: rtl/fcb_branch_eval.sv
module fcb_branch_eval #(
  parameter int PC_W  = 32,
  parameter int IMM_W = 16
) (
  input  logic             on_true,
  input  logic             likely,
  input  logic             cond,
  input  logic [PC_W-1:0]  pc,
  input  logic [IMM_W-1:0] imm,
  output logic             taken,
  output logic             nullify,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  target
);
  logic [PC_W-1:0] offs;

  assign offs    = {{(PC_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign seq_pc  = pc + PC_W'(4);
  assign target  = seq_pc + (offs << 2);
  assign taken   = on_true ? cond : !cond;
  assign nullify = likely && !taken;
endmodule

// File: rtl/fpu_ctrl_branch.sv
module fpu_ctrl_branch
  import fcb_pkg::*;
#(
  parameter int               PC_W     = 32,
  parameter int               IMM_W    = 16,
  parameter int               INT_W    = 64,
  parameter logic [CTL_W-1:0] IMPL_REV = 32'h0000_0A00
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                op_valid,
  input  logic [2:0]          op_code,
  input  logic                cop_usable,
  input  logic [IDX_W-1:0]    ctl_idx,
  input  logic [CTL_W-1:0]    int_wdata,
  input  logic [PC_W-1:0]     pc,
  input  logic [IMM_W-1:0]    imm,
  input  logic                divisor_zero,
  output logic                done,
  output logic                fault_unusable,
  output logic [PC_W-1:0]     next_pc,
  output logic                br_taken,
  output logic                nullify_slot,
  output logic                int_wen,
  output logic [INT_W-1:0]    int_rdata,
  output logic [RM_MODES-1:0] rnd_sel,
  output logic                div0_flag
);
  fop_e            op;
  logic            acc, is_br, on_true, likely, wr_en, dz_hit;
  logic [CTL_W-1:0] csr_q, csr_d, rd_data;
  logic            rd_hit, taken, nullify;
  logic [PC_W-1:0] seq_pc, target;

  assign op      = fop_e'(op_code);
  assign acc     = op_valid && cop_usable;
  assign is_br   = (op == FOP_BF) || (op == FOP_BT) || (op == FOP_BFL) || (op == FOP_BTL);
  assign on_true = (op == FOP_BT) || (op == FOP_BTL);
  assign likely  = (op == FOP_BFL) || (op == FOP_BTL);
  assign wr_en   = acc && (op == FOP_WR);
  assign dz_hit  = acc && (op == FOP_DIV) && divisor_zero && csr_q[DZ_EN_BIT];

  fcb_ctrl_regs #(.IMPL_REV(IMPL_REV)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .idx(ctl_idx), .wr_data(int_wdata),
    .csr_q(csr_q), .csr_d(csr_d), .rd_data(rd_data), .rd_hit(rd_hit)
  );

  fcb_round_decode u_rnd (
    .clk(clk), .rst(rst), .mode_next(csr_d[RM_W-1:0]), .sel_q(rnd_sel)
  );

  fcb_branch_eval #(.PC_W(PC_W), .IMM_W(IMM_W)) u_br (
    .on_true(on_true), .likely(likely), .cond(csr_q[COND_BIT]),
    .pc(pc), .imm(imm), .taken(taken), .nullify(nullify),
    .seq_pc(seq_pc), .target(target)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done           <= 1'b0;
      fault_unusable <= 1'b0;
      next_pc        <= '0;
      br_taken       <= 1'b0;
      nullify_slot   <= 1'b0;
      int_wen        <= 1'b0;
      int_rdata      <= '0;
      div0_flag      <= 1'b0;
    end else begin
      done           <= op_valid;
      fault_unusable <= op_valid && !cop_usable;
      br_taken       <= acc && is_br && taken;
      nullify_slot   <= acc && is_br && nullify;
      int_wen        <= acc && (op == FOP_RD) && rd_hit;
      div0_flag      <= dz_hit;
      if (acc && (op == FOP_RD) && rd_hit)
        int_rdata <= {{(INT_W-CTL_W){rd_data[CTL_W-1]}}, rd_data};
      if (op_valid) begin
        if (!cop_usable)        next_pc <= pc;
        else if (is_br && taken) next_pc <= target;
        else                    next_pc <= seq_pc;
      end
    end
  end

  // R9: a fault carries no side effect
  p_fault_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    fault_unusable |-> !int_wen && !br_taken && !nullify_slot && !div0_flag);
  p_fault_pc_r9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !cop_usable) |=> next_pc == $past(pc));
  // R8: nullify only on a not-taken branch
  p_nullify_r8: assert property (@(posedge clk) disable iff (rst)
    nullify_slot |-> !br_taken);
  // R10: divide-by-zero needs the enable bit
  p_div0_r10: assert property (@(posedge clk) disable iff (rst)
    div0_flag |-> $past(csr_q[DZ_EN_BIT] && divisor_zero && op_valid && cop_usable));
  // R11: completion follows issue
  p_done_r11: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> done);
endmodule

// File: tb/tb_fpu_ctrl_branch.sv
`timescale 1ns/1ps
module tb_fpu_ctrl_branch;
  localparam logic [31:0] ID_VAL = 32'h0000_0A00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic        cop_usable = 1'b1;
  logic [4:0]  ctl_idx = '0;
  logic [31:0] int_wdata = '0;
  logic [31:0] pc = '0;
  logic [15:0] imm = '0;
  logic        divisor_zero = 1'b0;
  logic        done, fault_unusable, br_taken, nullify_slot, int_wen, div0_flag;
  logic [31:0] next_pc;
  logic [63:0] int_rdata;
  logic [3:0]  rnd_sel;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;
  logic [31:0] m31 = '0;

  always #2 clk = ~clk;

  fpu_ctrl_branch dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .cop_usable(cop_usable), .ctl_idx(ctl_idx), .int_wdata(int_wdata),
    .pc(pc), .imm(imm), .divisor_zero(divisor_zero), .done(done),
    .fault_unusable(fault_unusable), .next_pc(next_pc), .br_taken(br_taken),
    .nullify_slot(nullify_slot), .int_wen(int_wen), .int_rdata(int_rdata),
    .rnd_sel(rnd_sel), .div0_flag(div0_flag)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] onehot_rm(input logic [1:0] m);
    return 4'b0001 << m;
  endfunction

  task automatic step(input logic [2:0] op, input logic use_c, input logic [4:0] idx,
                      input logic [31:0] wd, input logic [31:0] p, input logic [15:0] im,
                      input logic dz);
    bit e_fault, e_tk, e_nul, e_wen, e_dz, brop, cond;
    logic [31:0] e_pc;
    logic [63:0] e_rd;
    @(negedge clk);
    op_valid = 1'b1; op_code = op; cop_usable = use_c; ctl_idx = idx;
    int_wdata = wd; pc = p; imm = im; divisor_zero = dz;
    e_fault = !use_c;
    brop = (op >= 3'd2) && (op <= 3'd5);
    cond = m31[23];
    e_tk = 0; e_nul = 0; e_wen = 0; e_dz = 0; e_rd = '0;
    e_pc = p + 32'd4;
    if (!use_c) e_pc = p;
    else begin
      if (brop) begin
        e_tk = (op == 3'd3 || op == 3'd5) ? cond : !cond;
        e_nul = (op == 3'd4 || op == 3'd5) && !e_tk;
        if (e_tk) e_pc = p + 32'd4 + ({{16{im[15]}}, im} * 32'd4);
      end
      if (op == 3'd0 && (idx == 5'd31 || idx == 5'd0)) begin
        e_wen = 1;
        e_rd = (idx == 5'd31) ? {{32{m31[31]}}, m31} : {{32{ID_VAL[31]}}, ID_VAL};
      end
      if (op == 3'd6) e_dz = dz && m31[10];
    end
    if (use_c && op == 3'd1 && idx == 5'd31) m31 = wd;
    @(posedge clk); #1;
    chk(done == 1'b1, "R11 done", 64'(done), 64'd1);
    chk(fault_unusable == e_fault, "R9 fault", 64'(fault_unusable), 64'(e_fault));
    chk(next_pc == e_pc, brop ? "R7 next_pc" : (e_fault ? "R9 next_pc" : "R11 next_pc"), 64'(next_pc), 64'(e_pc));
    chk(br_taken == e_tk, "R6 taken", 64'(br_taken), 64'(e_tk));
    chk(nullify_slot == e_nul, "R8 nullify", 64'(nullify_slot), 64'(e_nul));
    chk(int_wen == e_wen, (op == 3'd0) ? "R3 int_wen" : "R9 int_wen", 64'(int_wen), 64'(e_wen));
    if (e_wen) chk(int_rdata == e_rd, "R2 rdata", int_rdata, e_rd);
    chk(div0_flag == e_dz, "R10 div0", 64'(div0_flag), 64'(e_dz));
    chk(rnd_sel == onehot_rm(m31[1:0]), "R5 rnd_sel", 64'(rnd_sel), 64'(onehot_rm(m31[1:0])));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: reset state
    chk(rnd_sel == 4'b0001, "R1 rnd_sel", 64'(rnd_sel), 64'd1);
    chk(!done && !fault_unusable && !br_taken && !nullify_slot && !int_wen && !div0_flag,
        "R1 pulses", 64'({done, fault_unusable, br_taken, nullify_slot, int_wen, div0_flag}), 64'd0);
    // R2 reads, R3 other index
    step(3'd0, 1, 5'd31, 0, 32'h100, 0, 0);
    step(3'd0, 1, 5'd0, 0, 32'h104, 0, 0);
    step(3'd0, 1, 5'd7, 0, 32'h108, 0, 0);
    // R5: all four rounding encodings
    for (int m = 0; m < 4; m++) step(3'd1, 1, 5'd31, 32'(m), 32'h200, 0, 0);
    // R4: ignored write to another index, then full-word store with sign
    step(3'd1, 1, 5'd5, 32'hFFFF_FFFF, 32'h210, 0, 0);
    step(3'd0, 1, 5'd31, 0, 32'h214, 0, 0);
    step(3'd1, 1, 5'd31, 32'h8080_0F83, 32'h218, 0, 0);
    step(3'd0, 1, 5'd31, 0, 32'h21C, 0, 0);
    // R6/R7/R8: condition set, all forms, positive and negative offsets
    for (int o = 2; o <= 5; o++) begin
      step(3'(o), 1, 0, 0, 32'h1000, 16'h0010, 0);
      step(3'(o), 1, 0, 0, 32'h1000, 16'hFFF0, 0);
    end
    // R10: enable set
    step(3'd6, 1, 0, 0, 32'h300, 0, 1);
    step(3'd6, 1, 0, 0, 32'h304, 0, 0);
    // condition clear, enable clear
    step(3'd1, 1, 5'd31, 32'h0000_0002, 32'h400, 0, 0);
    for (int o = 2; o <= 5; o++) step(3'(o), 1, 0, 0, 32'h2000, 16'h8000, 0);
    step(3'd6, 1, 0, 0, 32'h404, 0, 1);
    step(3'd7, 1, 0, 0, 32'h408, 0, 0);
    // R9: every op while unusable
    for (int o = 0; o < 8; o++) step(3'(o), 0, 5'd31, 32'h0080_0401, 32'h500, 16'h0004, 1);
    step(3'd0, 1, 5'd31, 0, 32'h520, 0, 0);
    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      logic [4:0] ix;
      ix = ($urandom % 3 == 0) ? 5'd31 : (($urandom % 2 == 0) ? 5'd0 : 5'($urandom));
      step(3'($urandom), ($urandom % 5) != 0, ix, $urandom, $urandom & 32'hFFFF_FFFC,
           16'($urandom), 1'($urandom));
    end
    @(negedge clk); op_valid = 1'b0;
    @(posedge clk); #1;
    chk(done == 1'b0, "R11 idle", 64'(done), 64'd0);
    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule